// File: doc/BRIEF.md
# Prescaled Reloading Periodic Wake Timer

This block generates periodic wake-up events for a microcontroller. It receives six tick sources as single-cycle enable strobes in the system clock domain: an external pin clock, a slow internal oscillator, a watchdog prescaler output, a watchdog overflow, the system clock and the system clock divided by twelve. A three-bit source code selects one of these strobes. The selected strobe advances a fifteen-stage binary prescaler. A four-bit tap code picks either one prescaler stage or the undivided strobe, and that choice becomes the tick of a six-bit up-counter.

When the counter passes its maximum it loads a programmable reload value. The overflow sets a sticky flag and flips a clock-out signal, so the clock-out runs at half the overflow rate. Software uses two byte registers: a control byte (run, clock-out enable, reload value) and a timer byte (upper tap bits, live count). The timer byte is locked while the timer runs. The source code and the two low tap bits come in as plain configuration inputs.

Top module: `wake_timer`

## Requirements
- R1: After reset the control readback is 0x3F (reload all ones, run and clock-out enable clear). The timer readback is 0x00, and the flag, `irq` and `clk_out` are 0.
- R2: Source code n (0..5) selects strobe bit n of `src_stb`: 0 pin clock, 1 slow oscillator, 2 watchdog prescaler, 3 watchdog overflow, 4 system clock, 5 system clock / 12. Codes 6 and 7 select no strobe, so no tick is produced. Strobes on unselected bits have no effect.
- R3: The tap code is `{tm bits 7:6, tap_lo}`. A code c in 0..14 gives one tick for every 2^(15-c) selected strobes (prescaler stage 14-c). Code 15 gives one tick for every strobe. The prescaler is held at zero while run is clear, so the first tick after enabling comes on the 2^(15-c)-th strobe.
- R4: Each tick while running increments the count. A tick at count 63 loads the reload value instead and sets the overflow flag.
- R5: Control byte layout: bit 7 run, bit 6 clock-out enable, bits 5:0 reload value. It is always writable and reads back as written.
- R6: Timer byte layout: bits 7:6 upper tap bits, bits 5:0 live count. It is written only while run is clear. Writes while run is set leave both fields unchanged.
- R7: While run is clear the count holds, whatever strobes arrive.
- R8: An internal toggle flips on every overflow. `clk_out` equals that toggle when clock-out enable is set and is 0 otherwise.
- R9: A flag write with data 0 clears the flag, and a flag write with data 1 has no effect. If an overflow occurs in the same cycle as a clear, the flag stays set.
- R10: `irq` is the AND of the flag and `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_stb | input | 6 | One-cycle enable strobes of the six tick sources |
| src_sel | input | 3 | Tick source code |
| tap_lo | input | 2 | Low two bits of the tap code |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| tm_wr | input | 1 | Timer byte write strobe |
| tm_wdata | input | 8 | Timer byte write data |
| tm_rdata | output | 8 | Timer byte readback (upper tap bits, live count) |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Flag write data, 0 clears |
| irq_en | input | 1 | Interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Clock output, half the overflow rate |

## Verification
The bench uses the default parameters: fifteen prescaler stages, a six-bit count and six sources. Because the prescaler is cleared while the timer is stopped, every tap's first tick falls on a known strobe count. This lets the table predict counts, wraps and clock-out parity per row. The deepest tap divides by 32768, which still fits the run time. A directed test steps to one strobe before and one strobe after that wrap to check the boundary exactly.

// File: rtl/wt_pkg.sv
`timescale 1ns/1ps
package wt_pkg;
    localparam int WT_STAGES = 15;
    localparam int WT_CNT_W  = 6;
    localparam int WT_NSRC   = 6;
    localparam int WT_SEL_W  = 3;
    localparam int WT_TAP_W  = 4;
    localparam int WT_LO_W   = 2;
endpackage

// File: rtl/wt_prescaler.sv
`timescale 1ns/1ps
module wt_prescaler #(
    parameter int STAGES = wt_pkg::WT_STAGES,
    parameter int NSRC   = wt_pkg::WT_NSRC,
    parameter int SEL_W  = wt_pkg::WT_SEL_W,
    parameter int TAP_W  = wt_pkg::WT_TAP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NSRC-1:0]  src_stb,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             tick
);
    typedef struct packed {
        logic [STAGES-1:0] pre;
    } pre_s;

    pre_s              st_d, st_q;
    logic              src_act;
    logic [STAGES-1:0] stg;

    // source selection: codes past NSRC select nothing
    always_comb begin
        src_act = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_sel == SEL_W'(i)) src_act = src_stb[i];
        end
    end

    // stage k completes a period when bits k..0 are all ones
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stg[k] = src_act & (&st_q.pre[k:0]);
    end

    // tap code c selects stage STAGES-1-c; codes beyond use the raw strobe
    always_comb begin
        tick = src_act;
        for (int k = 0; k < STAGES; k++) begin
            if (tap_sel == TAP_W'(STAGES - 1 - k)) tick = stg[k];
        end
    end

    always_comb begin
        st_d = st_q;
        if (!run)         st_d.pre = '0;
        else if (src_act) st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.pre == '0) else $error("prescaler not cleared"); // R3
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_act) |=> $stable(st_q.pre)) else $error("prescaler moved without strobe"); // R2
endmodule

// File: rtl/wt_reload_counter.sv
`timescale 1ns/1ps
module wt_reload_counter #(
    parameter int CNT_W = wt_pkg::WT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             tog
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             tog;
    } cnt_s;

    cnt_s st_d, st_q;
    logic step;
    logic wrap;

    assign step = run & tick & ~ld;
    assign wrap = step & (st_q.cnt == CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (ld)        st_d.cnt = ld_val;
        else if (wrap) st_d.cnt = reload;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;
        if (wrap)          st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
        if (wrap) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;
    assign tog  = st_q.tog;

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !ld && cnt == CNT_MAX) |=> cnt == $past(reload)) else $error("no reload"); // R4
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !ld && cnt == CNT_MAX) |=> flag) else $error("flag not set"); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(run && tick && !ld && cnt == CNT_MAX)) |=> !flag) else $error("flag not cleared"); // R9
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld) |=> $stable(cnt)) else $error("count moved while stopped"); // R7
    AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !ld && cnt == CNT_MAX) |=> tog != $past(tog)) else $error("no toggle"); // R8
endmodule

// File: rtl/wake_timer.sv
`timescale 1ns/1ps
module wake_timer #(
    parameter int STAGES = wt_pkg::WT_STAGES,
    parameter int CNT_W  = wt_pkg::WT_CNT_W,
    parameter int NSRC   = wt_pkg::WT_NSRC,
    parameter int SEL_W  = wt_pkg::WT_SEL_W,
    parameter int TAP_W  = wt_pkg::WT_TAP_W,
    parameter int LO_W   = wt_pkg::WT_LO_W,
    localparam int HI_W  = TAP_W - LO_W,
    localparam int REG_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_stb,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [LO_W-1:0]  tap_lo,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             tm_wr,
    input  logic [REG_W-1:0] tm_wdata,
    output logic [REG_W-1:0] tm_rdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             irq_en,
    output logic             ovf_flag,
    output logic             irq,
    output logic             clk_out
);
    typedef struct packed {
        logic             en;
        logic             oe;
        logic [CNT_W-1:0] reload;
        logic [HI_W-1:0]  tap_hi;
    } regs_s;

    regs_s            rg_d, rg_q;
    logic             tick;
    logic             ld;
    logic             flag_clr;
    logic [CNT_W-1:0] cnt;
    logic             tog;

    assign ld       = tm_wr & ~rg_q.en;
    assign flag_clr = flag_wr & ~flag_wdata;

    always_comb begin
        rg_d = rg_q;
        if (ctl_wr) begin
            rg_d.en     = ctl_wdata[REG_W-1];
            rg_d.oe     = ctl_wdata[REG_W-2];
            rg_d.reload = ctl_wdata[CNT_W-1:0];
        end
        if (ld) rg_d.tap_hi = tm_wdata[REG_W-1 -: HI_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q        <= '0;
            rg_q.reload <= {CNT_W{1'b1}};
        end else begin
            rg_q <= rg_d;
        end
    end

    wt_prescaler #(
        .STAGES(STAGES), .NSRC(NSRC), .SEL_W(SEL_W), .TAP_W(TAP_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rg_q.en),
        .src_stb (src_stb),
        .src_sel (src_sel),
        .tap_sel ({rg_q.tap_hi, tap_lo}),
        .tick    (tick)
    );

    wt_reload_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (rg_q.en),
        .tick     (tick),
        .ld       (ld),
        .ld_val   (tm_wdata[CNT_W-1:0]),
        .reload   (rg_q.reload),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .flag     (ovf_flag),
        .tog      (tog)
    );

    assign ctl_rdata = {rg_q.en, rg_q.oe, rg_q.reload};
    assign tm_rdata  = {rg_q.tap_hi, cnt};
    assign irq       = ovf_flag & irq_en;
    assign clk_out   = rg_q.oe & tog;

    AST_TM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.en |=> $stable(rg_q.tap_hi)) else $error("tap bits written while running"); // R6
    AST_CTL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_rdata == $past(ctl_wdata)) else $error("control readback"); // R5
    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.oe |-> !clk_out) else $error("clock-out not gated"); // R8
endmodule

// File: tb/sim_wake_timer.sv
`timescale 1ns/1ps
module sim_wake_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_stb = '0;
    logic [2:0] src_sel = '0;
    logic [1:0] tap_lo = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       tm_wr = 1'b0;
    logic [7:0] tm_wdata = '0;
    logic [7:0] tm_rdata;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       irq_en = 1'b0;
    logic       ovf_flag, irq, clk_out;

    int compared = 0;
    int mismatched = 0;
    bit tog_m = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wake_timer u0 (
        .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .src_sel(src_sel), .tap_lo(tap_lo),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .tm_wr(tm_wr), .tm_wdata(tm_wdata), .tm_rdata(tm_rdata),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .irq_en(irq_en),
        .ovf_flag(ovf_flag), .irq(irq), .clk_out(clk_out)
    );

    // mask, source, tap, reload, start, strobes, exp count, exp flag, overflows
    typedef struct packed {
        logic [5:0]  mask;
        logic [2:0]  src;
        logic [3:0]  tap;
        logic [5:0]  reload;
        logic [5:0]  start;
        logic [15:0] n;
        logic [5:0]  cnt;
        logic        flag;
        logic [3:0]  ovf;
    } vec_s;

    localparam int NV = 7;
    localparam vec_s VECS [NV] = '{
        '{6'h10, 3'd4, 4'd15, 6'd0,  6'd60, 16'd5,  6'd1,  1'b1, 4'd1},
        '{6'h01, 3'd0, 4'd14, 6'd10, 6'd62, 16'd6,  6'd11, 1'b1, 4'd1},
        '{6'h02, 3'd1, 4'd13, 6'd5,  6'd0,  16'd8,  6'd2,  1'b0, 4'd0},
        '{6'h3F, 3'd2, 4'd12, 6'd0,  6'd62, 16'd24, 6'd1,  1'b1, 4'd1},
        '{6'h37, 3'd3, 4'd15, 6'd0,  6'd7,  16'd10, 6'd7,  1'b0, 4'd0},
        '{6'h20, 3'd5, 4'd0,  6'd0,  6'd3,  16'd40, 6'd3,  1'b0, 4'd0},
        '{6'h20, 3'd5, 4'd15, 6'd63, 6'd63, 16'd4,  6'd63, 1'b1, 4'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_tm(input logic [7:0] d);
        tm_wr = 1'b1; tm_wdata = d;
        @(negedge clk);
        tm_wr = 1'b0;
    endtask

    task automatic wr_flag(input logic d);
        flag_wr = 1'b1; flag_wdata = d;
        @(negedge clk);
        flag_wr = 1'b0;
    endtask

    task automatic strobe(input logic [5:0] m, input int n);
        src_stb = m;
        repeat (n) @(negedge clk);
        src_stb = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 8'h3F);
        chk("R1 tm", tm_rdata, 8'h00);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 clk_out", clk_out, 0);
        chk("R1 irq", irq, 0);

        // table walk: R2 R3 R4 R8
        for (int i = 0; i < NV; i++) begin
            wr_ctl({2'b01, VECS[i].reload});
            wr_flag(1'b0);
            wr_tm({VECS[i].tap[3:2], VECS[i].start});
            tap_lo  = VECS[i].tap[1:0];
            src_sel = VECS[i].src;
            wr_ctl({2'b11, VECS[i].reload});
            strobe(VECS[i].mask, int'(VECS[i].n));
            tog_m ^= VECS[i].ovf[0];
            chk($sformatf("R4 count row %0d", i), tm_rdata[5:0], VECS[i].cnt);
            chk($sformatf("R2 flag row %0d", i), ovf_flag, VECS[i].flag);
            chk($sformatf("R8 clk_out row %0d", i), clk_out, tog_m);
        end

        // R6 timer write ignored while running (tap 15, count 63)
        wr_tm(8'h05);
        chk("R6 locked", tm_rdata, 8'hFF);

        // R9 write 1 no effect, write 0 clears
        wr_flag(1'b1);
        chk("R9 write one", ovf_flag, 1);
        wr_flag(1'b0);
        chk("R9 clear", ovf_flag, 0);

        // R9 overflow wins over clear (count 63, raw tap, source 5)
        src_stb = 6'h20; flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk);
        src_stb = '0; flag_wr = 1'b0;
        tog_m = ~tog_m;
        chk("R9 collision", ovf_flag, 1);

        // R10 interrupt gating
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10 irq on", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R10 irq off", irq, 0);

        // R8 clock-out gated by enable
        wr_ctl(8'hBF);
        chk("R8 gated", clk_out, 0);
        wr_ctl(8'hFF);
        chk("R8 ungated", clk_out, tog_m);

        // R7 hold while stopped
        wr_ctl(8'h7F);
        strobe(6'h3F, 5);
        chk("R7 hold", tm_rdata[5:0], 63);
        wr_tm(8'h8A);
        chk("R6 write when stopped", tm_rdata, 8'h8A);

        // R2 unused source code selects nothing
        wr_tm(8'hCA);
        tap_lo = 2'b11; src_sel = 3'd6;
        wr_ctl(8'hFF);
        strobe(6'h3F, 8);
        chk("R2 code 6 idle", tm_rdata[5:0], 8'h0A);

        // R3 deepest tap boundary
        wr_ctl(8'h54);
        wr_flag(1'b0);
        wr_tm(8'h3F);
        tap_lo = 2'b00; src_sel = 3'd4;
        wr_ctl(8'hD4);
        chk("R5 readback", ctl_rdata, 8'hD4);
        strobe(6'h10, 32767);
        chk("R3 before wrap", tm_rdata[5:0], 63);
        chk("R3 no flag yet", ovf_flag, 0);
        strobe(6'h10, 1);
        chk("R3 after wrap", tm_rdata[5:0], 20);
        chk("R4 flag at wrap", ovf_flag, 1);

        done = 1'b1;
        finish_run();
    end
endmodule